// File: doc/BRIEF.md
# CEC Bus Frame Receiver with Acknowledge

This block listens to one open-drain CEC line and turns the pulse-width coded bit stream into a frame of bytes. A one-microsecond tick enable paces a single elapsed-time counter. The counter restarts on every falling edge of the synchronised line. Against this counter the block qualifies the start bit, samples each data slot, and gathers bits into bytes, most significant bit first.

Each byte on the bus takes ten slots: eight data bits, an end-of-message flag and an acknowledge slot. The block watches the destination nibble of the first byte. When a directed frame names an address whose bit is set in the address mask, the block pulls the acknowledge slot low. A falling edge that arrives too early is answered with a long low pulse on the line that marks an error. A frame is handed over with a one-cycle valid strobe once the line is high again after the acknowledge slot of the last byte. Sending and arbitration belong to other blocks.

Top module: `cec_frame_rx`

## Requirements
- R1: A start bit whose low phase is shorter than START_LOW_MIN ticks is rejected. The block returns to idle, delivers nothing, and the previously delivered length and bytes stay as they were.
- R2: If the next falling edge does not come within START_TOTAL_MAX ticks of the start bit's falling edge, the block returns to idle and delivers nothing.
- R3: Each data slot is sampled SAMPLE_AT ticks after its falling edge; a high line reads 1. Slots 0 to 7 of a byte carry the data bits, most significant first. Byte k of the frame appears at frame_bytes[8k+7:8k].
- R4: Slot 8 is the end-of-message flag. After slot 9 of a byte whose flag read 1, once the line is high, frame_valid is high for exactly one cycle. frame_len is then that byte's index plus one.
- R5: The destination is bits 3:0 of byte 0. If it is not 15 and addr_mask has the bit for it set, the block drives line_pull_low for ACK_LOW ticks, starting at the falling edge of slot 9 of every byte.
- R6: A broadcast frame (destination 15), or a frame whose destination bit in addr_mask is clear, is never driven low by the block. It is still delivered.
- R7: A falling edge that comes less than BIT_MIN ticks after the previous falling edge inside a frame makes the block drive line_pull_low for ERR_LOW ticks. The block then returns to idle, and that frame is not delivered.
- R8: If the line stays high for more than BIT_MAX ticks after a bit's falling edge, without the delivery condition of R4, the frame is dropped and the block returns to idle. This drops it without driving the line.
- R9: Only the first MAX_BYTES bytes are stored. The data of later bytes is ignored, bit timing is still checked, acknowledges are still driven, and frame_len is capped at MAX_BYTES.
- R10: After reset, line_pull_low, frame_valid, frame_len and frame_bytes are all zero. The length and bytes change only after the next start bit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-microsecond time-base enable |
| addr_mask | input | 16 | One bit per logical address that this block answers |
| line_in | input | 1 | Sensed level of the CEC line |
| line_pull_low | output | 1 | 1 pulls the open-drain line low |
| frame_valid | output | 1 | One-cycle strobe when a frame is complete |
| frame_len | output | $clog2(MAX_BYTES+1) | Number of bytes in the frame |
| frame_bytes | output | 8*MAX_BYTES | Received bytes, byte k at bits 8k+7:8k |

## Verification
The bench builds the block with every timing parameter at one tenth of its nominal value and tick_us held high, so one tick is one clock. A whole multi-byte frame then fits in a few thousand cycles. MAX_BYTES is set to 4, so a six-byte frame reaches the storage cap while acknowledges continue. The reduced timings also bring the start-bit, short-bit and long-high limits within a few hundred cycles of each other, so each limit is crossed on purpose in its own scenario.

// File: rtl/cec_rx_pkg.sv
`timescale 1ns/1ps
package cec_rx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START_LO,
      RX_START_HI,
      RX_SAMPLE,
      RX_WAIT,
      RX_ACK,
      RX_ERR
   } rx_state_e;

   function automatic logic state_drives(input rx_state_e s);
      return (s == RX_ACK) || (s == RX_ERR);
   endfunction
endpackage

// File: rtl/cec_rx_sync.sv
`timescale 1ns/1ps
module cec_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level,
   output logic fall,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cec_rx_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], raw};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign fall  = prev & ~level;
   assign rise  = ~prev & level;
endmodule

// File: rtl/cec_rx_timer.sv
`timescale 1ns/1ps
module cec_rx_timer #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);
   if (CNT_W < 2) begin : g_bad_width
      $error("cec_rx_timer counter too narrow");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '1;
      else if (clr)             cnt <= '0;
      else if (tick && !(&cnt)) cnt <= cnt + 1'b1;
   end

   // R8
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (&cnt)) |=> (&cnt));
endmodule

// File: rtl/cec_rx_store.sv
`timescale 1ns/1ps
module cec_rx_store #(
   parameter int NB    = 16,
   parameter int IDX_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [2:0]      slot,
   input  logic            bit_val,
   output logic [NB*8-1:0] data
);
   if (NB < 1 || (1 << IDX_W) <= NB) begin : g_bad_depth
      $error("cec_rx_store index too narrow for depth");
   end

   for (genvar i = 0; i < NB; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            data[i*8 +: 8] <= '0;
         else if (clr)
            data[i*8 +: 8] <= '0;
         else if (wr_en && idx == IDX_W'(i))
            data[i*8 + 7 - int'(slot)] <= bit_val;
      end
   end

   // R9
   overflow_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr && idx >= IDX_W'(NB)) |=> $stable(data));
endmodule

// File: rtl/cec_frame_rx.sv
`timescale 1ns/1ps
module cec_frame_rx
   import cec_rx_pkg::*;
#(
   parameter int MAX_BYTES       = 16,
   parameter int START_LOW_MIN   = 3500,
   parameter int START_TOTAL_MAX = 4700,
   parameter int SAMPLE_AT       = 850,
   parameter int BIT_MIN         = 2050,
   parameter int BIT_MAX         = 2750,
   parameter int ACK_LOW         = 1500,
   parameter int ERR_LOW         = 3600,
   parameter int SYNC_STAGES     = 2,
   localparam int LEN_W          = $clog2(MAX_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick_us,
   input  logic [15:0]            addr_mask,
   input  logic                   line_in,
   output logic                   line_pull_low,
   output logic                   frame_valid,
   output logic [LEN_W-1:0]       frame_len,
   output logic [MAX_BYTES*8-1:0] frame_bytes
);
   localparam int T_MAX1 = (START_TOTAL_MAX > BIT_MAX) ? START_TOTAL_MAX : BIT_MAX;
   localparam int T_MAX2 = (ERR_LOW > ACK_LOW) ? ERR_LOW : ACK_LOW;
   localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
   localparam int CNT_W  = $clog2(T_MAX + 2) + 1;

   localparam logic [CNT_W-1:0] T_SLOW  = CNT_W'(START_LOW_MIN);
   localparam logic [CNT_W-1:0] T_STOT  = CNT_W'(START_TOTAL_MAX);
   localparam logic [CNT_W-1:0] T_SAMP  = CNT_W'(SAMPLE_AT);
   localparam logic [CNT_W-1:0] T_BMIN  = CNT_W'(BIT_MIN);
   localparam logic [CNT_W-1:0] T_BMAX  = CNT_W'(BIT_MAX);
   localparam logic [CNT_W-1:0] T_ACK   = CNT_W'(ACK_LOW);
   localparam logic [CNT_W-1:0] T_ERR   = CNT_W'(ERR_LOW);
   localparam logic [LEN_W-1:0] CAP     = LEN_W'(MAX_BYTES);

   if (START_LOW_MIN >= START_TOTAL_MAX || SAMPLE_AT >= BIT_MIN ||
       BIT_MIN >= BIT_MAX || ACK_LOW >= BIT_MIN || ERR_LOW < ACK_LOW ||
       MAX_BYTES < 1) begin : g_bad_timing
      $error("cec_frame_rx timing parameters inconsistent");
   end

   logic             s_line, fall, rise;
   logic [CNT_W-1:0] cnt;
   rx_state_e        state;
   logic [3:0]       slot;
   logic [LEN_W-1:0] byte_idx;
   logic             eom;
   logic             store_clr, store_wr;
   logic [3:0]       dest;
   logic             ack_me;

   cec_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(line_in),
      .level(s_line), .fall(fall), .rise(rise));

   cec_rx_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick_us), .clr(fall), .cnt(cnt));

   assign store_clr = (state == RX_START_HI) && fall;
   assign store_wr  = (state == RX_SAMPLE) && !fall && (cnt >= T_SAMP) && !slot[3];

   cec_rx_store #(.NB(MAX_BYTES), .IDX_W(LEN_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(store_clr), .wr_en(store_wr),
      .idx(byte_idx), .slot(slot[2:0]), .bit_val(s_line), .data(frame_bytes));

   assign dest   = frame_bytes[3:0];
   assign ack_me = (dest != 4'hF) && addr_mask[dest];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= RX_IDLE;
         slot        <= '0;
         byte_idx    <= '0;
         eom         <= 1'b0;
         frame_len   <= '0;
         frame_valid <= 1'b0;
      end else begin
         frame_valid <= 1'b0;
         unique case (state)
            RX_IDLE:
               if (fall) state <= RX_START_LO;
            RX_START_LO:
               if (rise)             state <= (cnt >= T_SLOW) ? RX_START_HI : RX_IDLE;
               else if (cnt > T_STOT) state <= RX_IDLE;
            RX_START_HI:
               if (fall) begin
                  state     <= RX_SAMPLE;
                  slot      <= '0;
                  byte_idx  <= '0;
                  eom       <= 1'b0;
                  frame_len <= '0;
               end else if (cnt > T_STOT) begin
                  state <= RX_IDLE;
               end
            RX_SAMPLE:
               if (fall) begin
                  state <= RX_ERR;
               end else if (cnt >= T_SAMP) begin
                  state <= RX_WAIT;
                  if (slot == 4'd8) begin
                     eom       <= s_line;
                     frame_len <= (byte_idx < CAP) ? byte_idx + 1'b1 : CAP;
                  end
               end
            RX_WAIT:
               if (fall) begin
                  if (cnt < T_BMIN) begin
                     state <= RX_ERR;
                  end else if (slot == 4'd9) begin
                     slot  <= '0;
                     state <= RX_SAMPLE;
                     if (byte_idx < CAP) byte_idx <= byte_idx + 1'b1;
                  end else begin
                     slot  <= slot + 1'b1;
                     state <= (slot == 4'd8 && ack_me) ? RX_ACK : RX_SAMPLE;
                  end
               end else if (slot == 4'd9 && eom && s_line) begin
                  frame_valid <= 1'b1;
                  state       <= RX_IDLE;
               end else if (s_line && cnt > T_BMAX) begin
                  state <= RX_IDLE;
               end
            RX_ACK:
               if (cnt >= T_ACK) state <= RX_WAIT;
            RX_ERR:
               if (cnt >= T_ERR) state <= RX_IDLE;
            default:
               state <= RX_IDLE;
         endcase
      end
   end

   assign line_pull_low = state_drives(state);

   // R4
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);
   // R4
   valid_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> (frame_len != '0));
   // R5
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_pull_low) |-> ($past(cnt) >= T_ACK));
   // R7
   drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_pull_low) |-> $past(fall));
endmodule

// File: tb/tb_cec_frame_rx.sv
`timescale 1ns/1ps
module tb_cec_frame_rx;
   localparam int NB    = 4;
   localparam int LEN_W = $clog2(NB + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tb_pull = 1'b0;
   logic [15:0]      addr_mask = 16'h0010;
   logic             line_in;
   logic             line_pull_low;
   logic             frame_valid;
   logic [LEN_W-1:0] frame_len;
   logic [NB*8-1:0]  frame_bytes;

   always #2.5 clk = ~clk;
   assign line_in = !(tb_pull || line_pull_low);

   cec_frame_rx #(
      .MAX_BYTES(NB), .START_LOW_MIN(350), .START_TOTAL_MAX(470),
      .SAMPLE_AT(85), .BIT_MIN(205), .BIT_MAX(275), .ACK_LOW(150),
      .ERR_LOW(360), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tick_us(1'b1), .addr_mask(addr_mask),
      .line_in(line_in), .line_pull_low(line_pull_low),
      .frame_valid(frame_valid), .frame_len(frame_len),
      .frame_bytes(frame_bytes));

   typedef struct {
      int         len;
      logic [7:0] b [NB];
   } exp_t;

   exp_t exp_q[$];
   int   errors = 0;
   int   checks = 0;
   int   pulses = 0;
   int   cur_dur = 0;
   int   last_dur = 0;
   logic prev_pull = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (line_pull_low && !prev_pull) begin
         pulses++;
         cur_dur = 1;
      end else if (line_pull_low) begin
         cur_dur++;
      end else if (prev_pull) begin
         last_dur = cur_dur;
      end
      prev_pull = line_pull_low;
      if (frame_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4 unexpected frame_valid", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(int'(frame_len) == e.len, "R4 frame_len", int'(frame_len), e.len);
            for (int k = 0; k < e.len; k++)
               chk(frame_bytes[k*8 +: 8] == e.b[k], "R3 frame byte",
                   int'(frame_bytes[k*8 +: 8]), int'(e.b[k]));
         end
      end
   end

   task automatic hold(input bit low, input int n);
      tb_pull = low;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input bit v);
      hold(1'b1, v ? 60 : 150);
      hold(1'b0, v ? 180 : 90);
   endtask

   task automatic send_start();
      hold(1'b1, 370);
      hold(1'b0, 80);
   endtask

   task automatic send_frame(input logic [7:0] fb [8], input int n);
      exp_t e;
      e.len = (n < NB) ? n : NB;
      for (int k = 0; k < NB; k++) e.b[k] = fb[k];
      exp_q.push_back(e);
      pulses = 0;
      send_start();
      for (int i = 0; i < n; i++) begin
         for (int j = 7; j >= 0; j--) send_bit(fb[i][j]);
         send_bit(i == n - 1);
         send_bit(1'b1);
      end
      hold(1'b0, 300);
      chk(exp_q.size() == 0, "R4 frame delivered", exp_q.size(), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "watchdog expired", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] fb [8];
      logic [NB*8-1:0] snap_bytes;
      int snap_len;
      repeat (5) @(negedge clk);
      // R10 reset state
      chk(line_pull_low == 1'b0, "R10 reset pull", int'(line_pull_low), 0);
      chk(frame_valid == 1'b0, "R10 reset valid", int'(frame_valid), 0);
      chk(frame_len == '0, "R10 reset len", int'(frame_len), 0);
      chk(frame_bytes == '0, "R10 reset bytes", int'(frame_bytes[31:0]), 0);
      rst_n = 1'b1;
      hold(1'b0, 50);

      // R5: directed to address 4, mask bit 4 set
      fb = '{8'h14, 8'h36, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      send_frame(fb, 3);
      chk(pulses == 3, "R5 ack pulses", pulses, 3);
      chk(last_dur >= 145 && last_dur <= 160, "R5 ack width", last_dur, 151);

      // R6: broadcast
      fb = '{8'h2F, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      send_frame(fb, 2);
      chk(pulses == 0, "R6 broadcast no ack", pulses, 0);

      // R6: destination 5 with mask bit clear
      fb = '{8'h35, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      send_frame(fb, 1);
      chk(pulses == 0, "R6 unaddressed no ack", pulses, 0);

      // R9: six bytes, only four stored, acks continue
      fb = '{8'h44, 8'hC3, 8'h5A, 8'hFF, 8'h12, 8'h34, 8'h00, 8'h00};
      send_frame(fb, 6);
      chk(pulses == 6, "R9 ack beyond storage", pulses, 6);
      chk(frame_bytes == {8'hFF, 8'h5A, 8'hC3, 8'h44}, "R9 stored bytes",
          int'(frame_bytes[31:0]), 32'hFF5AC344);

      snap_len = int'(frame_len);
      snap_bytes = frame_bytes;

      // R1: short start low
      pulses = 0;
      hold(1'b1, 300);
      hold(1'b0, 80);
      for (int j = 0; j < 10; j++) send_bit(j[0]);
      hold(1'b0, 400);
      chk(int'(frame_len) == snap_len, "R1 len kept", int'(frame_len), snap_len);
      chk(frame_bytes == snap_bytes, "R1 bytes kept", int'(frame_bytes[31:0]),
          int'(snap_bytes[31:0]));
      chk(pulses == 0, "R1 no drive", pulses, 0);

      // R2: start period too long
      hold(1'b1, 370);
      hold(1'b0, 200);
      for (int j = 0; j < 10; j++) send_bit(1'b1);
      hold(1'b0, 400);
      chk(frame_bytes == snap_bytes, "R2 bytes kept", int'(frame_bytes[31:0]),
          int'(snap_bytes[31:0]));
      chk(pulses == 0, "R2 no drive", pulses, 0);

      // R8: line left high mid-frame
      send_start();
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b1);
      hold(1'b0, 500);
      chk(pulses == 0, "R8 abandon without drive", pulses, 0);
      chk(line_pull_low == 1'b0, "R8 line released", int'(line_pull_low), 0);

      // R7: bit period too short
      send_start();
      send_bit(1'b1);
      hold(1'b1, 60);
      hold(1'b0, 90);
      hold(1'b1, 60);
      hold(1'b0, 600);
      chk(pulses == 1, "R7 error pulse count", pulses, 1);
      chk(last_dur >= 355 && last_dur <= 370, "R7 error pulse width", last_dur, 361);

      // R4: recovery frame after error
      fb = '{8'h14, 8'h7E, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      send_frame(fb, 2);
      chk(pulses == 2, "R5 ack after recovery", pulses, 2);

      // R10: outputs stay stable while idle
      snap_bytes = frame_bytes;
      hold(1'b0, 200);
      chk(frame_bytes == snap_bytes, "R10 stable idle", int'(frame_bytes[31:0]),
          int'(snap_bytes[31:0]));
      chk(frame_len == LEN_W'(2), "R10 len stable", int'(frame_len), 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule